// File: doc/BRIEF.md
# Compact 16-bit Load/Store Processor Core

This block is a single-issue, in-order processor with a 16-bit datapath. It runs a fixed twelve-instruction set over eight 16-bit general registers. Instruction memory and data memory are separate, and each is a 64 KB byte-addressed space. Every instruction word is 16 bits, and the core retires one instruction per clock. It has an ALU (move, add, subtract, OR, AND), a compare-and-branch, an absolute jump, and word loads and stores that use base-plus-offset addressing.

The instruction port reads synchronously. The core drives the byte address of the instruction it needs next, and the word at that address arrives one clock later. The data port gives load data combinationally in the same cycle and takes a store on the clock edge. Both spaces are little-endian: a 16-bit word holds the byte at the even address in bits 7:0 and the byte at the odd address in bits 15:8. Reset is asserted asynchronously and released synchronously inside the block. A jump whose target is its own address stops the core and raises a sticky stop flag.

Top module: `mini16_core`

## Requirements
- R1: While reset is held and after it is released, the core starts with the program counter at byte 0 and all eight registers at 0. `halt` is low, `dmem_we` is low and `imem_addr` is 0 until the first instruction executes.
- R2: An instruction word is split into these fields: opcode in bits 15:12, register index X in bits 11:9, register index Y in bits 8:6, a 9-bit immediate in bits 8:0, a 6-bit immediate in bits 5:0, and a 12-bit target in bits 11:0. Opcode 0 writes the sign-extended 9-bit immediate to register X. Opcode 1 adds that immediate to X. Opcode 2 subtracts it from X.
- R3: Opcodes 3 to 7 write register X with, in order: Y; X+Y; X−Y; X OR Y; X AND Y. Sums and differences wrap modulo 2^16.
- R4: Opcode 9 loads register X from the word at Y + sext(imm6). The word is read little-endian from the even-aligned address, so bit 0 of the address is ignored by the memory.
- R5: Opcode 10 stores register X to the address Y + sext(imm6). For exactly one cycle it drives that full address on `dmem_addr`, drives X on `dmem_wdata` and raises `dmem_we`.
- R6: Opcode 11 branches to PC + 2 + 2·sext(imm6) when register X equals register Y. Otherwise execution continues at PC + 2.
- R7: Opcode 8 jumps to the byte address formed from PC bits 15:13, then the 12-bit target, then a 0 bit.
- R8: Opcodes 12 to 15 change no register, store nothing, and advance to PC + 2.
- R9: Instructions retire one per clock. Two events separated by n instructions are seen exactly n cycles apart.
- R10: A jump to its own address raises `halt` on the next cycle. `halt` then stays high, no further store is made, and `imem_addr` stays at that address until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| imem_addr | output | 16 | Byte address of the next instruction to fetch |
| imem_rdata | input | 16 | Instruction word for the previous cycle's address |
| dmem_addr | output | 16 | Data byte address for a load or store |
| dmem_we | output | 1 | Store strobe |
| dmem_wdata | output | 16 | Store data |
| dmem_rdata | input | 16 | Load data, valid in the same cycle |
| halt | output | 1 | Sticky stop flag |

## Verification
The bench builds the core with its default parameters: eight registers and a two-stage reset synchronizer. These defaults give every 3-bit register field a real register to reach. With the full 16-bit program counter, one program can run sequentially across the 8 KB boundary. A jump on the far side then shows that the upper three PC bits carry into the target. A reference model of the instruction set predicts every store address, store value and retire spacing, and the cycle in which the core stops.

// File: rtl/mini16_pkg.sv
package mini16_pkg;
  localparam int WORD_W  = 16;
  localparam int RIDX_W  = 3;
  localparam int IMM9_W  = 9;
  localparam int IMM6_W  = 6;
  localparam int TGT_W   = 12;

  localparam logic [3:0] OPC_MOVI = 4'd0;
  localparam logic [3:0] OPC_ADDI = 4'd1;
  localparam logic [3:0] OPC_SUBI = 4'd2;
  localparam logic [3:0] OPC_MOV  = 4'd3;
  localparam logic [3:0] OPC_ADD  = 4'd4;
  localparam logic [3:0] OPC_SUB  = 4'd5;
  localparam logic [3:0] OPC_OR   = 4'd6;
  localparam logic [3:0] OPC_AND  = 4'd7;
  localparam logic [3:0] OPC_JMP  = 4'd8;
  localparam logic [3:0] OPC_LD   = 4'd9;
  localparam logic [3:0] OPC_ST   = 4'd10;
  localparam logic [3:0] OPC_BEQ  = 4'd11;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_OR,
    ALU_AND
  } alu_op_e;

  typedef struct packed {
    logic                rf_we;
    logic                use_imm;
    logic                is_load;
    logic                is_store;
    logic                is_jump;
    logic                is_branch;
    alu_op_e             alu_op;
    logic [RIDX_W-1:0]   rx;
    logic [RIDX_W-1:0]   ry;
    logic [WORD_W-1:0]   imm9_x;
    logic [WORD_W-1:0]   imm6_x;
    logic [TGT_W-1:0]    tgt;
  } ctrl_t;
endpackage

// File: rtl/mini16_rst_sync.sv
module mini16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mini16_decode.sv
module mini16_decode
  import mini16_pkg::*;
(
  input  logic [WORD_W-1:0] insn,
  output ctrl_t             ctrl
);
  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_PASS;
    ctrl.rx     = insn[11:9];
    ctrl.ry     = insn[8:6];
    ctrl.imm9_x = {{(WORD_W-IMM9_W){insn[IMM9_W-1]}}, insn[IMM9_W-1:0]};
    ctrl.imm6_x = {{(WORD_W-IMM6_W){insn[IMM6_W-1]}}, insn[IMM6_W-1:0]};
    ctrl.tgt    = insn[TGT_W-1:0];
    case (insn[15:12])
      OPC_MOVI: begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_PASS; end
      OPC_ADDI: begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_ADD;  end
      OPC_SUBI: begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SUB;  end
      OPC_MOV:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_PASS; end
      OPC_ADD:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_ADD;  end
      OPC_SUB:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_SUB;  end
      OPC_OR:   begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_OR;   end
      OPC_AND:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_AND;  end
      OPC_JMP:  ctrl.is_jump   = 1'b1;
      OPC_LD:   begin ctrl.rf_we = 1'b1; ctrl.is_load = 1'b1; end
      OPC_ST:   ctrl.is_store  = 1'b1;
      OPC_BEQ:  ctrl.is_branch = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/mini16_regfile.sv
module mini16_regfile #(
  parameter int NREG = 8,
  parameter int W    = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0]    regs_q [NREG];
  logic [W-1:0]    regs_d [NREG];
  logic [NREG-1:0] wsel;

  for (genvar g = 0; g < NREG; g++) begin : g_wsel
    assign wsel[g] = we && (waddr == AW'(g));
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regs_d[i] = wsel[i] ? wdata : regs_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
    end
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];

  // A write is visible at the addressed register on the next cycle (R3)
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/mini16_alu.sv
module mini16_alu
  import mini16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      ALU_AND: y = a & b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/mini16_core.sv
module mini16_core
  import mini16_pkg::*;
#(
  parameter int NREG       = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [WORD_W-1:0] imem_addr,
  input  logic [WORD_W-1:0] imem_rdata,
  output logic [WORD_W-1:0] dmem_addr,
  output logic              dmem_we,
  output logic [WORD_W-1:0] dmem_wdata,
  input  logic [WORD_W-1:0] dmem_rdata,
  output logic              halt
);
  localparam int W   = WORD_W;
  localparam int RAW = $clog2(NREG);

  logic          srst_n;
  logic [W-1:0]  pc_q, pc_d, seq_pc, br_pc, jmp_pc, tgt_pc;
  logic          valid_q, valid_d, halt_q, halt_d;
  logic          exec_en, operands_eq;
  ctrl_t         ctrl;
  logic [W-1:0]  rx_val, ry_val, alu_b, alu_y, rf_wdata;
  logic          rf_we;

  mini16_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  mini16_decode u_dec (.insn(imem_rdata), .ctrl(ctrl));

  mini16_regfile #(.NREG(NREG), .W(W)) u_rf (
    .clk(clk), .rst_n(srst_n),
    .we(rf_we), .waddr(RAW'(ctrl.rx)), .wdata(rf_wdata),
    .raddr_a(RAW'(ctrl.rx)), .raddr_b(RAW'(ctrl.ry)),
    .rdata_a(rx_val), .rdata_b(ry_val)
  );

  assign alu_b = ctrl.use_imm ? ctrl.imm9_x : ry_val;

  mini16_alu #(.W(W)) u_alu (.op(ctrl.alu_op), .a(rx_val), .b(alu_b), .y(alu_y));

  assign exec_en     = valid_q && !halt_q;
  assign operands_eq = (rx_val == ry_val);
  assign seq_pc      = pc_q + W'(2);
  assign br_pc       = seq_pc + (ctrl.imm6_x << 1);
  assign jmp_pc      = {pc_q[W-1:TGT_W+1], ctrl.tgt, 1'b0};

  always_comb begin
    tgt_pc = seq_pc;
    if (ctrl.is_jump) begin
      tgt_pc = jmp_pc;
    end else if (ctrl.is_branch && operands_eq) begin
      tgt_pc = br_pc;
    end
    pc_d    = pc_q;
    valid_d = 1'b1;
    halt_d  = halt_q;
    if (exec_en) begin
      pc_d = tgt_pc;
      if (ctrl.is_jump && (jmp_pc == pc_q)) halt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pc_q    <= '0;
      valid_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      valid_q <= valid_d;
      halt_q  <= halt_d;
    end
  end

  assign rf_we      = exec_en && ctrl.rf_we;
  assign rf_wdata   = ctrl.is_load ? dmem_rdata : alu_y;
  assign dmem_addr  = ry_val + ctrl.imm6_x;
  assign dmem_we    = exec_en && ctrl.is_store;
  assign dmem_wdata = rx_val;
  assign imem_addr  = pc_d;
  assign halt       = halt_q;

  // Nothing executes before the first fetched word arrives (R1)
  assert_idle_before_fetch_R1: assert property (@(posedge clk) disable iff (!srst_n)
    !valid_q |-> (!dmem_we && !halt_q && pc_q == '0));

  // Decoded classes are mutually exclusive (R2)
  assert_class_onehot_R2: assert property (@(posedge clk) disable iff (!srst_n)
    exec_en |-> $onehot0({ctrl.is_load, ctrl.is_store, ctrl.is_jump, ctrl.is_branch}));

  // Taken compare-and-branch lands on the scaled offset (R6)
  assert_branch_target_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (exec_en && ctrl.is_branch && operands_eq) |=>
      pc_q == $past(pc_q) + W'(2) + ($past(ctrl.imm6_x) << 1));

  // Straight-line instructions advance by one word per cycle (R9)
  assert_seq_step_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (exec_en && !ctrl.is_jump && !ctrl.is_branch) |=> pc_q == $past(pc_q) + W'(2));

  // Stop state is sticky and freezes the program counter (R10)
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!srst_n)
    halt_q |=> (halt_q && $stable(pc_q)));

  // No store once stopped (R10)
  assert_no_store_halted_R10: assert property (@(posedge clk) disable iff (!srst_n)
    halt_q |-> !dmem_we);
endmodule

// File: tb/mini16_core_tb_top.sv
`timescale 1ns/1ps
module mini16_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, halt;

  always #4 clk = ~clk;

  mini16_core dut_i (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata), .halt(halt)
  );

  // ---------------- memories ----------------
  logic [7:0] imem [int];
  logic [7:0] dbyte [0:2047];
  logic [7:0] mdm [int];

  function automatic logic [7:0] ib(int a);
    return imem.exists(a) ? imem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] mb(int a);
    return mdm.exists(a) ? mdm[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    imem_rdata <= {ib(int'(imem_addr) + 1), ib(int'(imem_addr))};
    if (dmem_we) begin
      dbyte[{dmem_addr[10:1], 1'b0}] = dmem_wdata[7:0];
      dbyte[{dmem_addr[10:1], 1'b1}] = dmem_wdata[15:8];
    end
  end
  assign dmem_rdata = {dbyte[{dmem_addr[10:1], 1'b1}], dbyte[{dmem_addr[10:1], 1'b0}]};

  // ---------------- check bookkeeping ----------------
  int n_checks = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- assembler ----------------
  int asm_pc;
  function automatic logic [15:0] e_ri(int op, int rx, int imm);
    return 16'(((op & 15) << 12) | ((rx & 7) << 9) | (imm & 'h1FF));
  endfunction
  function automatic logic [15:0] e_rr(int op, int rx, int ry);
    return 16'(((op & 15) << 12) | ((rx & 7) << 9) | ((ry & 7) << 6));
  endfunction
  function automatic logic [15:0] e_m(int op, int rx, int ry, int imm);
    return 16'(((op & 15) << 12) | ((rx & 7) << 9) | ((ry & 7) << 6) | (imm & 'h3F));
  endfunction
  function automatic logic [15:0] e_j(int tgt);
    return 16'((8 << 12) | (tgt & 'hFFF));
  endfunction

  task automatic emit(input logic [15:0] w);
    imem[asm_pc]     = w[7:0];
    imem[asm_pc + 1] = w[15:8];
    asm_pc += 2;
  endtask
  task automatic emit_halt();
    emit(e_j((asm_pc >> 1) & 'hFFF));
  endtask
  task automatic poke(input int a, input logic [7:0] b);
    dbyte[a] = b;
    mdm[a]   = b;
  endtask
  task automatic new_prog();
    imem.delete();
    mdm.delete();
    for (int i = 0; i < 2048; i++) dbyte[i] = 8'h00;
    asm_pc = 0;
  endtask

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [15:0] addr;
    logic [15:0] data;
    int          step;
    string       tag;
  } item_t;
  item_t exp_q[$];
  item_t cur_it;
  string cur_tag;
  int    m_halt_step;
  logic [15:0] m_halt_pc;

  // Reference model of the instruction set, pushes expected stores
  task automatic run_model(input string tag);
    logic [15:0] r [8];
    logic [15:0] pc, npc, w, i9, i6, a;
    int x, y;
    bit done;
    for (int k = 0; k < 8; k++) r[k] = 16'h0;
    pc = 16'h0;
    done = 0;
    m_halt_step = -1;
    for (int step = 0; step < 1000 && !done; step++) begin
      w   = {ib(int'(pc) + 1), ib(int'(pc))};
      x   = int'(w[11:9]);
      y   = int'(w[8:6]);
      i9  = {{7{w[8]}}, w[8:0]};
      i6  = {{10{w[5]}}, w[5:0]};
      npc = pc + 16'd2;
      a   = r[y] + i6;
      case (w[15:12])
        4'd0:  r[x] = i9;
        4'd1:  r[x] = r[x] + i9;
        4'd2:  r[x] = r[x] - i9;
        4'd3:  r[x] = r[y];
        4'd4:  r[x] = r[x] + r[y];
        4'd5:  r[x] = r[x] - r[y];
        4'd6:  r[x] = r[x] | r[y];
        4'd7:  r[x] = r[x] & r[y];
        4'd8: begin
          npc = {pc[15:13], w[11:0], 1'b0};
          if (npc == pc) begin
            m_halt_step = step;
            m_halt_pc   = pc;
            done        = 1;
          end
        end
        4'd9:  r[x] = {mb(int'(a | 16'h1)), mb(int'(a & 16'hFFFE))};
        4'd10: begin
          exp_q.push_back('{addr: a, data: r[x], step: step, tag: tag});
          mdm[int'(a & 16'hFFFE)]     = r[x][7:0];
          mdm[int'(a & 16'hFFFE) + 1] = r[x][15:8];
        end
        4'd11: if (r[x] == r[y]) npc = pc + 16'd2 + (i6 << 1);
        default: ;
      endcase
      pc = npc;
    end
  endtask

  // Monitor: pops and compares stores, tracks retire spacing and stop
  int cyc = 0;
  bit first_seen, halt_seen;
  int first_cyc, first_step, halt_cyc;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (dmem_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected store", 32'(dmem_addr), 32'hFFFFFFFF);
        end else begin
          cur_it = exp_q.pop_front();
          chk(dmem_addr == cur_it.addr, cur_it.tag, "store address", 32'(dmem_addr), 32'(cur_it.addr));
          chk(dmem_wdata == cur_it.data, cur_it.tag, "store data", 32'(dmem_wdata), 32'(cur_it.data));
          if (!first_seen) begin
            first_seen = 1;
            first_cyc  = cyc;
            first_step = cur_it.step;
          end else begin
            chk((cyc - first_cyc) == (cur_it.step - first_step), "R9", "store spacing",
                32'(cyc - first_cyc), 32'(cur_it.step - first_step));
          end
        end
      end
      if (halt && !halt_seen) begin
        halt_seen = 1;
        halt_cyc  = cyc;
      end
    end
  end

  // Driver: predicts, resets, runs, and checks the stop state
  task automatic run_prog(input string tag);
    exp_q.delete();
    cur_tag = tag;
    run_model(tag);
    @(negedge clk); #1;
    rst_n      = 1'b0;
    first_seen = 0;
    halt_seen  = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(halt == 1'b0, "R1", "halt during reset", 32'(halt), 0);
    chk(dmem_we == 1'b0, "R1", "store strobe during reset", 32'(dmem_we), 0);
    chk(imem_addr == 16'h0, "R1", "fetch address during reset", 32'(imem_addr), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 3000 && !halt_seen; k++) @(posedge clk);
    if (!halt_seen) begin
      chk(1'b0, "R10", "stop never raised", 0, 1);
    end else if (first_seen) begin
      chk((halt_cyc - first_cyc) == (m_halt_step - first_step + 1), "R10", "stop timing",
          32'(halt_cyc - first_cyc), 32'(m_halt_step - first_step + 1));
    end
    chk(exp_q.size() == 0, tag, "stores outstanding", 32'(exp_q.size()), 0);
    repeat (4) @(negedge clk);
    #1;
    chk(halt == 1'b1, "R10", "stop is sticky", 32'(halt), 1);
    chk(imem_addr == m_halt_pc, "R10", "fetch address frozen", 32'(imem_addr), 32'(m_halt_pc));
  endtask

  // ---------------- programs ----------------
  initial begin
    // R2: immediate forms, sign extension at the 9-bit limits
    new_prog();
    emit(e_ri(0, 1, 5));
    emit(e_ri(0, 2, -3));
    emit(e_m(10, 1, 0, 0));
    emit(e_m(10, 2, 0, 2));
    emit(e_ri(0, 3, 255));
    emit(e_m(10, 3, 0, 4));
    emit(e_ri(0, 4, -256));
    emit(e_m(10, 4, 0, 6));
    emit(e_ri(1, 1, -7));
    emit(e_m(10, 1, 0, 8));
    emit(e_ri(2, 3, -1));
    emit(e_m(10, 3, 0, 10));
    emit_halt();
    run_prog("R2");

    // R3: register-register forms and 16-bit wrap
    new_prog();
    emit(e_ri(0, 1, -2));
    emit(e_ri(0, 2, -3));
    emit(e_ri(0, 3, 255));
    emit(e_ri(1, 3, 1));
    emit(e_ri(0, 7, -1));
    emit(e_m(10, 7, 0, 0));
    emit(e_rr(3, 5, 2));
    emit(e_m(10, 5, 0, 2));
    emit(e_rr(4, 5, 1));
    emit(e_m(10, 5, 0, 4));
    emit(e_rr(5, 6, 3));
    emit(e_m(10, 6, 0, 6));
    emit(e_rr(6, 1, 3));
    emit(e_m(10, 1, 0, 8));
    emit(e_rr(7, 2, 3));
    emit(e_m(10, 2, 0, 10));
    emit(e_rr(4, 7, 7));
    emit(e_m(10, 7, 0, 12));
    emit_halt();
    run_prog("R3");

    // R4: loads, little-endian byte placement, odd effective address
    new_prog();
    poke(16'h100, 8'h34); poke(16'h101, 8'h12);
    poke(16'h10E, 8'hEF); poke(16'h10F, 8'hBE);
    emit(e_ri(0, 1, 255));
    emit(e_ri(1, 1, 17));
    emit(e_m(9, 2, 1, -16));
    emit(e_m(9, 3, 1, -2));
    emit(e_m(10, 2, 0, 0));
    emit(e_m(10, 3, 0, 2));
    emit(e_m(10, 3, 1, 4));
    emit(e_m(9, 4, 1, 4));
    emit(e_rr(4, 4, 2));
    emit(e_m(10, 4, 0, 4));
    emit(e_m(9, 5, 1, -15));
    emit(e_m(10, 5, 0, 6));
    emit_halt();
    run_prog("R4");

    // R5: store offsets at both 6-bit limits, same register as base and data
    new_prog();
    emit(e_ri(0, 2, 100));
    emit(e_ri(0, 1, -77));
    emit(e_m(10, 1, 2, -32));
    emit(e_m(10, 1, 2, 31));
    emit(e_m(10, 2, 2, 0));
    emit(e_m(9, 3, 2, 31));
    emit(e_m(10, 3, 0, 0));
    emit_halt();
    run_prog("R5");

    // R6: taken forward, not taken, backward loop
    new_prog();
    emit(e_ri(0, 1, 2));
    emit(e_ri(0, 2, 2));
    emit(e_m(11, 1, 2, 1));
    emit(e_m(10, 1, 0, 0));
    emit(e_ri(0, 3, 1));
    emit(e_m(11, 1, 3, 5));
    emit(e_m(10, 3, 0, 2));
    emit(e_ri(0, 4, 3));
    emit(e_ri(2, 4, 1));
    emit(e_m(10, 4, 0, 4));
    emit(e_m(11, 4, 0, 1));
    emit(e_m(11, 0, 0, -4));
    emit_halt();
    run_prog("R6");

    // R7: jump, sequential crossing of the 8 KB region, upper PC bits kept
    new_prog();
    emit(e_ri(0, 1, 7));
    emit(e_j('hFFC));
    emit(e_m(10, 1, 0, 0));
    asm_pc = 'h1FF8;
    emit(e_m(10, 1, 0, 2));
    emit(e_ri(1, 1, 1));
    emit(e_m(10, 1, 0, 4));
    emit(e_ri(0, 2, 9));
    emit(e_j('h010));
    emit(e_m(10, 1, 0, 8));
    asm_pc = 'h2020;
    emit(e_m(10, 2, 0, 6));
    emit_halt();
    run_prog("R7");

    // R8: unused opcodes; r7 also proves reset cleared registers (R1)
    new_prog();
    emit(e_ri(0, 1, 33));
    emit(16'hC000);
    emit(16'hDFFF);
    emit(16'hE249);
    emit(16'hF123);
    emit(e_m(10, 1, 0, 0));
    emit(e_m(10, 7, 0, 2));
    emit_halt();
    run_prog("R8");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #800000;
    n_err++;
    $display("FAIL R10 watchdog expired: actual running expected stopped");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule